// File: doc/BRIEF.md
# Six-bit step attenuator controller

This block drives the switch array of a six-bit step attenuator. It produces an active-low control word, one bit per binary-weighted attenuation pad, from one of two sources. The first is a three-wire serial port: data, shift clock and a load strobe. The second is a six-bit parallel bus that the strobe either passes straight through or captures. A select input chooses between the serial and parallel sources. The serial port also has a pass-through output, so several controllers can share one serial line in a chain.

After reset the controller waits a programmable number of clock cycles, which stands in for the slow settling of the supply. During that wait it drives the word for maximum attenuation. When the wait ends it loads a start-up word. If the strobe is low at that moment, two strap inputs pick the word from a fixed four-entry table. If the strobe is high, the parallel bus supplies the word.

The serial clock and the strobe are sampled by the block's own clock, and their edges are found by comparing each sample with the previous one. An optional chain of synchronizer stages can be placed in front of the sampled control inputs.

Top module: `atten_ctrl`

## Requirements
- R1: From reset release until `PWRUP_CYCLES` rising clock edges have passed, `atten_ctl` is all zeros (maximum attenuation), whatever the other inputs do. The start-up word appears after exactly that many edges.
- R2: If `le` is low when the wait ends, the start-up word depends on {`pup_b`,`pup_a`} as follows: 00 gives 6'b000000 (31.5 dB), 01 gives 6'b001111 (24 dB), 10 gives 6'b011111 (16 dB) and 11 gives 6'b111111 (0 dB).
- R3: If `le` is high when the wait ends, the start-up word is `par_d`.
- R4: `ser_mode`=1 selects serial control and `ser_mode`=0 selects parallel control. In serial mode, changes on `par_d` do not change `atten_ctl`. In parallel mode, rising edges on `sclk` do not shift, so `ser_out` stays the same.
- R5: In serial mode, each rising edge of `sclk` with `le` low shifts `sdata` into the shift register, most significant bit first. `atten_ctl` changes only on a rising edge of `le`, which copies the six most recent bits to the output in the order they arrived (first bit becomes bit 5).
- R6: In serial mode, `sclk` edges that occur while `le` is high do not shift. A later `le` pulse loads the bits that were present before those edges.
- R7: `ser_out` is the sixth most recent serial bit shifted in, counting the latest one. It changes only on a shift, so a bit comes out six shift edges after it went in.
- R8: In parallel mode with `le` high, `atten_ctl` equals `par_d` in the same cycle.
- R9: In parallel mode, when `le` falls, `atten_ctl` keeps the last `par_d` value seen while `le` was high, until `le` goes high again.
- R10: The control bits are active low, with weights in half-dB: bit i cleared adds 2^i half-dB. So bit 0 adds 0.5 dB and bit 5 adds 16 dB, and all bits cleared gives 31.5 dB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all serial-port and strobe edges are sampled with it |
| rst_n | input | 1 | Active-low reset; starts the power-up wait when released |
| ser_mode | input | 1 | 1 = serial control, 0 = parallel control |
| sclk | input | 1 | Serial shift clock |
| sdata | input | 1 | Serial data, most significant bit first |
| le | input | 1 | Load strobe / parallel pass-through enable |
| par_d | input | NBITS | Parallel control word, active low |
| pup_a | input | 1 | Start-up table select, low bit |
| pup_b | input | 1 | Start-up table select, high bit |
| atten_ctl | output | NBITS | Active-low control word to the switch array |
| ser_out | output | 1 | Serial pass-through for chaining |

## Verification
The assertions check on every cycle the properties that a single cycle can decide. They check that the output is held at maximum attenuation until the start-up word is loaded. They check that in serial mode the output moves only after a strobe rising edge, and that in latched parallel mode it holds while the strobe stays low. They check that direct parallel mode passes `par_d` through. They check that the pass-through output changes only on a qualified shift edge. Other behaviours need the bench's scenarios, because they depend on values over many cycles. These are: the exact content of the four start-up table entries, the length of the power-up wait, the bit order of a loaded serial word, the six-shift delay to the pass-through output, shift edges masked while the strobe is high, and the half-dB weighting of the bits.

// File: rtl/atten_ctrl_pkg.sv
package atten_ctrl_pkg;

   // start-up table select, encoded as {pup_b, pup_a}
   typedef enum logic [1:0] {
      SEL_MAX    = 2'b00,
      SEL_UPPER2 = 2'b01,
      SEL_UPPER1 = 2'b10,
      SEL_NONE   = 2'b11
   } pup_sel_e;

   // number of control inputs passed through the optional synchronizer
   localparam int unsigned CTRL_SYNC_W = 6;

endpackage

// File: rtl/atten_in_sync.sv
module atten_in_sync #(
   parameter int unsigned WIDTH  = 6,
   parameter int unsigned STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign d_out = d_in;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         for (genvar s = 0; s < int'(STAGES); s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  stage_q[s] <= '0;
               end else begin
                  stage_q[s] <= (s == 0) ? d_in : stage_q[(s == 0) ? 0 : s - 1];
               end
            end
         end
         assign d_out = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/atten_shift.sv
module atten_shift #(
   parameter int unsigned NBITS = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_s,
   input  logic             sclk_s,
   input  logic             sdata_s,
   input  logic             le_s,
   output logic [NBITS-1:0] shift_q,
   output logic             sclk_prev,
   output logic             ser_out
);

   logic shift_en;

   // a shift needs serial mode, a sampled clock rise and the strobe low
   assign shift_en = mode_s && sclk_s && !sclk_prev && !le_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q   <= '0;
         sclk_prev <= 1'b0;
      end else begin
         sclk_prev <= sclk_s;
         if (shift_en) begin
            shift_q <= {shift_q[NBITS-2:0], sdata_s};
         end
      end
   end

   assign ser_out = shift_q[NBITS-1];

endmodule

// File: rtl/atten_pwrup.sv
module atten_pwrup
   import atten_ctrl_pkg::*;
#(
   parameter int unsigned NBITS        = 6,
   parameter int unsigned PWRUP_CYCLES = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             le_s,
   input  logic             pup_a_s,
   input  logic             pup_b_s,
   input  logic [NBITS-1:0] par_d,
   output logic             ready,
   output logic             init_load,
   output logic [NBITS-1:0] init_word
);

   localparam int unsigned CW = $clog2(PWRUP_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(PWRUP_CYCLES - 1);

   localparam logic [NBITS-1:0] W_MAX    = '0;
   localparam logic [NBITS-1:0] W_UPPER2 = {2'b00, {(NBITS-2){1'b1}}};
   localparam logic [NBITS-1:0] W_UPPER1 = {1'b0, {(NBITS-1){1'b1}}};
   localparam logic [NBITS-1:0] W_NONE   = '1;

   logic [CW-1:0]    cnt_q;
   pup_sel_e         sel;
   logic [NBITS-1:0] table_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ready <= 1'b0;
      end else if (!ready) begin
         if (cnt_q == LAST) begin
            ready <= 1'b1;
         end else begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   assign init_load = !ready && (cnt_q == LAST);
   assign sel       = pup_sel_e'({pup_b_s, pup_a_s});

   always_comb begin
      unique case (sel)
         SEL_MAX:    table_word = W_MAX;
         SEL_UPPER2: table_word = W_UPPER2;
         SEL_UPPER1: table_word = W_UPPER1;
         default:    table_word = W_NONE;
      endcase
   end

   assign init_word = le_s ? par_d : table_word;

endmodule

// File: rtl/atten_ctrl.sv
module atten_ctrl
   import atten_ctrl_pkg::*;
#(
   parameter int unsigned NBITS        = 6,
   parameter int unsigned PWRUP_CYCLES = 64,
   parameter int unsigned SYNC_STAGES  = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_mode,
   input  logic             sclk,
   input  logic             sdata,
   input  logic             le,
   input  logic [NBITS-1:0] par_d,
   input  logic             pup_a,
   input  logic             pup_b,
   output logic [NBITS-1:0] atten_ctl,
   output logic             ser_out
);

   generate
      if (NBITS < 2) begin : g_bad_nbits
         $error("atten_ctrl: NBITS must be at least 2");
      end
      if (PWRUP_CYCLES < 1) begin : g_bad_pwrup
         $error("atten_ctrl: PWRUP_CYCLES must be at least 1");
      end
   endgenerate

   logic [CTRL_SYNC_W-1:0] raw_in, syn_in;
   logic mode_s, sclk_s, sdata_s, le_s, pup_a_s, pup_b_s;

   assign raw_in = {ser_mode, sclk, sdata, le, pup_a, pup_b};

   atten_in_sync #(.WIDTH(CTRL_SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (raw_in),
      .d_out (syn_in)
   );

   assign {mode_s, sclk_s, sdata_s, le_s, pup_a_s, pup_b_s} = syn_in;

   logic [NBITS-1:0] shift_q;
   logic             sclk_prev;

   atten_shift #(.NBITS(NBITS)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_s    (mode_s),
      .sclk_s    (sclk_s),
      .sdata_s   (sdata_s),
      .le_s      (le_s),
      .shift_q   (shift_q),
      .sclk_prev (sclk_prev),
      .ser_out   (ser_out)
   );

   logic             pwr_ready, init_load;
   logic [NBITS-1:0] init_word;

   atten_pwrup #(.NBITS(NBITS), .PWRUP_CYCLES(PWRUP_CYCLES)) u_pwrup (
      .clk       (clk),
      .rst_n     (rst_n),
      .le_s      (le_s),
      .pup_a_s   (pup_a_s),
      .pup_b_s   (pup_b_s),
      .par_d     (par_d),
      .ready     (pwr_ready),
      .init_load (init_load),
      .init_word (init_word)
   );

   logic [NBITS-1:0] hold_q;
   logic             le_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         le_prev <= 1'b0;
      end else begin
         le_prev <= le_s;
         if (init_load) begin
            hold_q <= init_word;
         end else if (pwr_ready) begin
            if (mode_s && le_s && !le_prev) begin
               hold_q <= shift_q;
            end else if (!mode_s && le_s) begin
               hold_q <= par_d;
            end
         end
      end
   end

   always_comb begin
      if (!pwr_ready) begin
         atten_ctl = '0;
      end else if (!mode_s && le_s) begin
         atten_ctl = par_d;
      end else begin
         atten_ctl = hold_q;
      end
   end

endmodule

// File: rtl/atten_ctrl_chk.sv
module atten_ctrl_chk #(
   parameter int unsigned NBITS = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ready,
   input logic             mode_s,
   input logic             le_s,
   input logic             sclk_s,
   input logic             sclk_prev,
   input logic [NBITS-1:0] par_d,
   input logic [NBITS-1:0] atten_ctl,
   input logic             ser_out
);

   // R1
   pwrup_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (atten_ctl == '0));

   // R5
   serial_only_on_le_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && $past(ready) && mode_s && $past(mode_s)
       && !($past(le_s) && !$past(le_s, 2))) |-> $stable(atten_ctl));

   // R7
   ser_out_on_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode_s && sclk_s && !sclk_prev && !le_s) |=> $stable(ser_out));

   // R8
   direct_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !mode_s && le_s) |-> (atten_ctl == par_d));

   // R9
   latched_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && $past(ready) && !mode_s && !$past(mode_s)
       && !le_s && !$past(le_s)) |-> $stable(atten_ctl));

endmodule

bind atten_ctrl atten_ctrl_chk #(.NBITS(NBITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ready     (pwr_ready),
   .mode_s    (mode_s),
   .le_s      (le_s),
   .sclk_s    (sclk_s),
   .sclk_prev (sclk_prev),
   .par_d     (par_d),
   .atten_ctl (atten_ctl),
   .ser_out   (ser_out)
);

// File: tb/atten_ctrl_tb.sv
module atten_ctrl_tb;

   localparam int NB = 6;
   localparam int PW = 64;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          ser_mode = 1'b1, sclk = 1'b0, sdata = 1'b0, le = 1'b0;
   logic [NB-1:0] par_d = '0;
   logic          pup_a = 1'b0, pup_b = 1'b0;
   logic [NB-1:0] atten_ctl;
   logic          ser_out;

   atten_ctrl #(.NBITS(NB), .PWRUP_CYCLES(PW), .SYNC_STAGES(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .sclk(sclk),
      .sdata(sdata), .le(le), .par_d(par_d), .pup_a(pup_a), .pup_b(pup_b),
      .atten_ctl(atten_ctl), .ser_out(ser_out)
   );

   int    total = 0;
   int    bad   = 0;
   bit    done  = 1'b0;
   string phase = "R1";

   task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // behavioural reference model
   bit            m_ready;
   int            m_cnt;
   logic [NB-1:0] m_hold;
   logic [NB-1:0] m_word;
   bit            m_sclk_p, m_le_p;
   bit            m_q[$];

   function automatic logic [NB-1:0] pup_word(logic a, logic b);
      case ({b, a})
         2'b00:   return 6'b000000;
         2'b01:   return 6'b001111;
         2'b10:   return 6'b011111;
         default: return 6'b111111;
      endcase
   endfunction

   function automatic int halfdb(logic [NB-1:0] v);
      int s = 0;
      for (int i = 0; i < NB; i++) if (!v[i]) s += (1 << i);
      return s;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ready = 1'b0; m_cnt = 0; m_hold = '0; m_sclk_p = 1'b0; m_le_p = 1'b0;
         m_q.delete();
         for (int i = 0; i < NB; i++) m_q.push_back(1'b0);
      end else begin
         for (int i = 0; i < NB; i++) m_word[NB-1-i] = m_q[i];
         if (!m_ready) begin
            m_cnt++;
            if (m_cnt == PW) begin
               m_ready = 1'b1;
               m_hold  = le ? par_d : pup_word(pup_a, pup_b);
            end
         end else if (ser_mode && le && !m_le_p) begin
            m_hold = m_word;
         end else if (!ser_mode && le) begin
            m_hold = par_d;
         end
         if (ser_mode && sclk && !m_sclk_p && !le) begin
            m_q.push_back(sdata);
            void'(m_q.pop_front());
         end
         m_sclk_p = sclk;
         m_le_p   = le;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done && m_q.size() == NB) begin
         logic [NB-1:0] e;
         e = m_ready ? ((!ser_mode && le) ? par_d : m_hold) : '0;
         chk(phase, 32'(atten_ctl), 32'(e));
         chk("R7", 32'(ser_out), 32'(m_q[0]));
      end
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic do_reset(logic m, logic l, logic [NB-1:0] d, logic a, logic b,
                           string req, logic [NB-1:0] expw);
      rst_n = 1'b0;
      ser_mode = m; le = l; par_d = d; pup_a = a; pup_b = b; sclk = 1'b0;
      phase = "R1";
      step(3);
      rst_n = 1'b1;
      step(PW - 1);
      @(negedge clk);
      chk("R1", 32'(atten_ctl), 32'h0);
      step(1);
      @(negedge clk);
      chk(req, 32'(atten_ctl), 32'(expw));
      phase = req;
      step(1);
   endtask

   task automatic shift_bit(logic b);
      sdata = b; sclk = 1'b0; step(1);
      sclk = 1'b1; step(1);
      sclk = 1'b0; step(1);
   endtask

   task automatic shift_word(logic [NB-1:0] w);
      for (int i = NB - 1; i >= 0; i--) shift_bit(w[i]);
   endtask

   task automatic pulse_le();
      le = 1'b1; step(2);
      le = 1'b0; step(2);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      step(2);
      // power-up table, strobe low
      do_reset(1'b1, 1'b0, 6'b010101, 1'b0, 1'b0, "R2", 6'b000000);
      do_reset(1'b1, 1'b0, 6'b010101, 1'b1, 1'b0, "R2", 6'b001111);
      do_reset(1'b1, 1'b0, 6'b010101, 1'b0, 1'b1, "R2", 6'b011111);
      do_reset(1'b1, 1'b0, 6'b010101, 1'b1, 1'b1, "R2", 6'b111111);
      // power-up from parallel bus, strobe high
      do_reset(1'b1, 1'b1, 6'b100101, 1'b1, 1'b1, "R3", 6'b100101);
      le = 1'b0; step(2);

      // R4: parallel bus ignored in serial mode
      phase = "R4";
      par_d = 6'b000011; step(3);
      @(negedge clk);
      chk("R4", 32'(atten_ctl), 32'(6'b100101));

      // R5: serial load, MSB first
      phase = "R5";
      shift_word(6'b101100);
      @(negedge clk);
      chk("R5", 32'(atten_ctl), 32'(6'b100101));
      pulse_le();
      @(negedge clk);
      chk("R5", 32'(atten_ctl), 32'(6'b101100));
      chk("R7", 32'(ser_out), 32'(1));
      shift_word(6'b010011);
      @(negedge clk);
      chk("R5", 32'(atten_ctl), 32'(6'b101100));
      pulse_le();
      @(negedge clk);
      chk("R5", 32'(atten_ctl), 32'(6'b010011));

      // R7: pass-through delay
      phase = "R7";
      shift_bit(1'b1);
      @(negedge clk);
      chk("R7", 32'(ser_out), 32'(1));
      shift_bit(1'b0);
      @(negedge clk);
      chk("R7", 32'(ser_out), 32'(0));

      // R6: shifting masked while strobe high
      phase = "R6";
      le = 1'b1; step(2);
      shift_word(6'b111111);
      @(negedge clk);
      chk("R6", 32'(ser_out), 32'(0));
      le = 1'b0; step(2);
      pulse_le();
      @(negedge clk);
      chk("R6", 32'(atten_ctl), 32'(6'b001110));

      // R8 / R10: direct parallel
      phase = "R8";
      ser_mode = 1'b0; le = 1'b1;
      par_d = 6'b110110;
      @(negedge clk);
      chk("R8", 32'(atten_ctl), 32'(6'b110110));
      par_d = 6'b000000;
      @(negedge clk);
      chk("R10", 32'(halfdb(atten_ctl)), 32'(63));
      par_d = 6'b111110;
      @(negedge clk);
      chk("R10", 32'(halfdb(atten_ctl)), 32'(1));
      par_d = 6'b011111;
      @(negedge clk);
      chk("R10", 32'(halfdb(atten_ctl)), 32'(32));
      par_d = 6'b111111;
      @(negedge clk);
      chk("R10", 32'(halfdb(atten_ctl)), 32'(0));

      // R9: latched parallel hold
      phase = "R9";
      step(1);
      par_d = 6'b101001; step(1);
      le = 1'b0; step(1);
      par_d = 6'b010101; step(2);
      @(negedge clk);
      chk("R9", 32'(atten_ctl), 32'(6'b101001));
      le = 1'b1;
      @(negedge clk);
      chk("R8", 32'(atten_ctl), 32'(6'b010101));
      step(1);
      le = 1'b0; step(1);
      par_d = 6'b000000; step(2);
      @(negedge clk);
      chk("R9", 32'(atten_ctl), 32'(6'b010101));

      // R4: serial clock ignored in parallel mode
      phase = "R4";
      shift_word(6'b101010);
      @(negedge clk);
      chk("R4", 32'(ser_out), 32'(0));
      chk("R4", 32'(atten_ctl), 32'(6'b010101));

      step(2);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule